// File: doc/BRIEF.md
# LCD Scanline Timing Generator

This block produces the raster timing for a 240x160 liquid-crystal panel. A clock divider turns every four system clocks into one pixel slot; a column counter walks through 240 visible slots and then 68 horizontal-blank slots, so one scanline takes 1232 clocks. A line counter steps at the end of every scanline. It runs through the 160 visible lines and then keeps counting through 68 vertical-blank lines, 228 lines and 280896 clocks per frame. The block presents horizontal-blank and vertical-blank flags and the current line number on its ports.

Software programs a 16-bit status/control register through a single write strobe. The register holds an 8-bit trigger line and three interrupt enable bits. When read, it also returns the live vertical-blank, horizontal-blank and line-match flags. For each of the three conditions (vertical blank begins, horizontal blank begins, line equals trigger), an interrupt output gives a one-clock pulse when the condition first becomes true. The pulse appears only if that condition's enable bit is set. The pixel and line geometry are parameters, so a test build can shrink a frame to a few hundred clocks.

Top module: `lcd_scan_timer`

## Requirements
- R1: The column advances once every CLKS_PER_PIX clocks (default 4). It counts 0 to H_VIS+H_BLANK-1 (default 0..307) and then wraps. `hblank` is 1 exactly while the column is H_VIS (240) or more, which is clock offsets 960..1231 of each 1232-clock line.
- R2: `line_num` goes up by one at the end of each line. It counts 0 to V_VIS+V_BLANK-1 (default 0..227), keeps counting through blanking and then wraps to 0. `vblank` is 1 exactly while `line_num` is V_VIS (160) or more.
- R3: `cfg_rdata` has this layout. Bit 0 is the vertical-blank flag, bit 1 the horizontal-blank flag and bit 2 the line-match flag. Bit 3 enables the vertical-blank interrupt, bit 4 the horizontal-blank interrupt and bit 5 the line-match interrupt. Bits 7:6 read 0, and bits 15:8 hold the trigger line.
- R4: The line-match flag (bit 2) is 1 exactly while `line_num` equals the trigger value, including during blank lines and across the wrap to line 0.
- R5: Each interrupt output is a single-clock pulse in the first clock its condition holds. For `irq_hblank` this is line offset H_VIS*CLKS_PER_PIX. For `irq_vblank` it is the first clock of line V_VIS. For `irq_match` it is the first clock of the matching line.
- R6: An interrupt output never pulses while its enable bit is 0. The flags keep updating regardless of the enables.
- R7: A write with `cfg_wr` high loads bits 15:8 and 5:3 from `cfg_wdata`. Written values in bits 2:0 and 7:6 have no effect.
- R8: A synchronous reset (`rst` high) sets the divider, the column and the line to 0, and clears the trigger, the enables and all interrupt outputs. After reset `cfg_rdata` reads 0x0004, because line 0 equals trigger 0.
- R9: If the trigger is rewritten to equal the current line while bit 5 is set, `irq_match` pulses once in the clock after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Write strobe for the status/control register |
| cfg_wdata | input | 16 | Write data for the status/control register |
| cfg_rdata | output | 16 | Status/control register readback |
| line_num | output | 8 | Current scanline number |
| hblank | output | 1 | Horizontal-blank flag |
| vblank | output | 1 | Vertical-blank flag |
| irq_vblank | output | 1 | Vertical-blank-start interrupt pulse |
| irq_hblank | output | 1 | Horizontal-blank-start interrupt pulse |
| irq_match | output | 1 | Line-match interrupt pulse |

## Verification
The hardest case to reach from the ports is a match edge that does not come from the counters. This happens when software moves the trigger onto the line already being scanned, in the middle of that line. The bench builds a reduced geometry so that whole frames pass in a few hundred clocks. It then waits until its own cycle count places the raster mid-line and writes that line as the trigger. It expects exactly one `irq_match` pulse in the clock after the write. The frame wrap from the last blank line to line 0 is covered by putting the trigger on line 0 and on the last line.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

  // Interrupt enable group, packed in register bit order 5..3
  typedef struct packed {
    logic en_match;
    logic en_hbl;
    logic en_vbl;
  } lcd_en_t;

  // Full 16-bit status/control word
  typedef struct packed {
    logic [7:0] trigger;
    logic [1:0] spare;
    lcd_en_t    en;
    logic       st_match;
    logic       st_hbl;
    logic       st_vbl;
  } lcd_stat_t;

  // One-clock pulse on the first cycle a condition holds
  function automatic logic edge_pulse(input logic cur, input logic prev, input logic en);
    return cur & ~prev & en;
  endfunction

endpackage

// File: rtl/lcd_hcount.sv
module lcd_hcount #(
  parameter  int CLKS_PER_PIX = 4,
  parameter  int H_VIS        = 240,
  parameter  int H_BLANK      = 68,
  localparam int H_TOTAL      = H_VIS + H_BLANK,
  localparam int COL_W        = $clog2(H_TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [COL_W-1:0] col,
  output logic             pix_tick,
  output logic             line_end,
  output logic             hblank
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_TOTAL - 1);
  localparam logic [COL_W-1:0] HVIS_C   = COL_W'(H_VIS);

  function automatic logic [COL_W-1:0] col_next(input logic [COL_W-1:0] c);
    return (c == COL_LAST) ? '0 : c + 1'b1;
  endfunction

  function automatic logic in_hblank(input logic [COL_W-1:0] c);
    return c >= HVIS_C;
  endfunction

  generate
    if (CLKS_PER_PIX > 1) begin : g_div
      localparam int DIV_W = $clog2(CLKS_PER_PIX);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_PIX - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst)                   div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end
      assign pix_tick = (div_q == DIV_LAST);
    end else begin : g_nodiv
      assign pix_tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           col <= '0;
    else if (pix_tick) col <= col_next(col);
  end

  assign line_end = pix_tick && (col == COL_LAST);
  assign hblank   = in_hblank(col);

  // R1: column stays inside one line
  p_col_range_r1: assert property (@(posedge clk) disable iff (rst)
    col <= COL_LAST);
  // R1: column only moves on a pixel tick
  p_col_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !pix_tick |=> $stable(col));
  // R1: column steps by one inside a line
  p_col_step_r1: assert property (@(posedge clk) disable iff (rst)
    (pix_tick && col != COL_LAST) |=> col == $past(col) + 1'b1);

endmodule

// File: rtl/lcd_vcount.sv
module lcd_vcount #(
  parameter int V_VIS   = 160,
  parameter int V_BLANK = 68,
  parameter int LINE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_end,
  output logic [LINE_W-1:0] line,
  output logic              vblank
);

  localparam int V_TOTAL = V_VIS + V_BLANK;
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(V_TOTAL - 1);
  localparam logic [LINE_W-1:0] VVIS_C    = LINE_W'(V_VIS);

  function automatic logic [LINE_W-1:0] line_next(input logic [LINE_W-1:0] l);
    return (l == LINE_LAST) ? '0 : l + 1'b1;
  endfunction

  function automatic logic in_vblank(input logic [LINE_W-1:0] l);
    return l >= VVIS_C;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)           line <= '0;
    else if (line_end) line <= line_next(line);
  end

  assign vblank = in_vblank(line);

  // R2: line count stays inside the frame
  p_line_range_r2: assert property (@(posedge clk) disable iff (rst)
    line <= LINE_LAST);
  // R2: line only moves at the end of a line
  p_line_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(line));
  // R2: last blank line wraps to line 0
  p_line_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (line_end && line == LINE_LAST) |=> line == '0);

endmodule

// File: rtl/lcd_irq_regs.sv
module lcd_irq_regs
  import lcd_tim_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        hblank,
  input  logic        vblank,
  input  logic [7:0]  line,
  output logic [15:0] rdata,
  output logic        line_match,
  output logic        irq_vblank,
  output logic        irq_hblank,
  output logic        irq_match
);

  logic [7:0] trig_q;
  lcd_en_t    en_q;
  logic       vbl_q, hbl_q, mat_q;
  lcd_stat_t  stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      trig_q <= wdata[15:8];
      en_q   <= lcd_en_t'(wdata[5:3]);
    end
  end

  assign line_match = (line == trig_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      vbl_q <= 1'b0;
      hbl_q <= 1'b0;
      mat_q <= 1'b0;
    end else begin
      vbl_q <= vblank;
      hbl_q <= hblank;
      mat_q <= line_match;
    end
  end

  assign irq_vblank = edge_pulse(vblank,     vbl_q, en_q.en_vbl);
  assign irq_hblank = edge_pulse(hblank,     hbl_q, en_q.en_hbl);
  assign irq_match  = edge_pulse(line_match, mat_q, en_q.en_match);

  always_comb begin
    stat          = '0;
    stat.trigger  = trig_q;
    stat.en       = en_q;
    stat.st_match = line_match;
    stat.st_hbl   = hblank;
    stat.st_vbl   = vblank;
  end
  assign rdata = stat;

  // R6: no pulse without its enable
  p_vbl_gate_r6: assert property (@(posedge clk) disable iff (rst)
    irq_vblank |-> rdata[3]);
  p_hbl_gate_r6: assert property (@(posedge clk) disable iff (rst)
    irq_hblank |-> rdata[4]);
  p_mat_gate_r6: assert property (@(posedge clk) disable iff (rst)
    irq_match |-> rdata[5]);
  // R5: pulses last one clock
  p_hbl_single_r5: assert property (@(posedge clk) disable iff (rst)
    irq_hblank |=> !irq_hblank);
  p_vbl_single_r5: assert property (@(posedge clk) disable iff (rst)
    irq_vblank |=> !irq_vblank);
  p_mat_single_r5: assert property (@(posedge clk) disable iff (rst)
    irq_match |=> !irq_match);
  // R5: a pulse marks a fresh condition
  p_hbl_fresh_r5: assert property (@(posedge clk) disable iff (rst)
    irq_hblank |-> (hblank && !$past(hblank)));
  // R7: configuration holds between writes; written data is fully known
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(rdata[15:8]) && $stable(rdata[5:3])));
  p_wdata_known_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$isunknown(wdata));

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int CLKS_PER_PIX = 4,
  parameter int H_VIS        = 240,
  parameter int H_BLANK      = 68,
  parameter int V_VIS        = 160,
  parameter int V_BLANK      = 68
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  output logic [7:0]  line_num,
  output logic        hblank,
  output logic        vblank,
  output logic        irq_vblank,
  output logic        irq_hblank,
  output logic        irq_match
);

  localparam int LINE_W = 8;
  localparam int COL_W  = $clog2(H_VIS + H_BLANK);
  localparam logic [COL_W-1:0]  HVIS_C = COL_W'(H_VIS);
  localparam logic [LINE_W-1:0] VVIS_C = LINE_W'(V_VIS);

  // Internal events brought out for checking
  logic [COL_W-1:0] col;
  logic             pix_tick;
  logic             line_end;
  logic             line_match;

  lcd_hcount #(
    .CLKS_PER_PIX(CLKS_PER_PIX),
    .H_VIS       (H_VIS),
    .H_BLANK     (H_BLANK)
  ) u_h (
    .clk     (clk),
    .rst     (rst),
    .col     (col),
    .pix_tick(pix_tick),
    .line_end(line_end),
    .hblank  (hblank)
  );

  lcd_vcount #(
    .V_VIS  (V_VIS),
    .V_BLANK(V_BLANK),
    .LINE_W (LINE_W)
  ) u_v (
    .clk     (clk),
    .rst     (rst),
    .line_end(line_end),
    .line    (line_num),
    .vblank  (vblank)
  );

  lcd_irq_regs u_r (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr),
    .wdata     (cfg_wdata),
    .hblank    (hblank),
    .vblank    (vblank),
    .line      (line_num),
    .rdata     (cfg_rdata),
    .line_match(line_match),
    .irq_vblank(irq_vblank),
    .irq_hblank(irq_hblank),
    .irq_match (irq_match)
  );

  // R1: horizontal blank starts at the first blank column
  p_hbl_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(hblank) |-> col == HVIS_C);
  // R2: vertical blank starts on line V_VIS, column 0
  p_vbl_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(vblank) |-> (line_num == VVIS_C && col == '0));
  // R4: a new match only begins with a line change or a write
  p_match_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(line_match) |-> ($past(line_end) || $past(cfg_wr)));

endmodule

// File: tb/sim_lcd_scan_timer.sv
`timescale 1ns/1ps
module sim_lcd_scan_timer;

  localparam int CPP   = 2;
  localparam int HV    = 6;
  localparam int HB    = 3;
  localparam int VV    = 5;
  localparam int VB    = 3;
  localparam int HT    = HV + HB;
  localparam int VT    = VV + VB;
  localparam int LINE  = HT * CPP;
  localparam int FRAME = LINE * VT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [7:0]  line_num;
  logic        hblank, vblank, irq_vblank, irq_hblank, irq_match;

  int n_chk = 0;
  int n_fail = 0;
  int t = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) t <= 0;
    else     t <= t + 1;
  end

  lcd_scan_timer #(
    .CLKS_PER_PIX(CPP), .H_VIS(HV), .H_BLANK(HB), .V_VIS(VV), .V_BLANK(VB)
  ) u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .line_num(line_num), .hblank(hblank),
    .vblank(vblank), .irq_vblank(irq_vblank), .irq_hblank(irq_hblank),
    .irq_match(irq_match)
  );

  // Expected raster position from elapsed clocks
  function automatic int e_line(int tt); return (tt / LINE) % VT; endfunction
  function automatic bit e_hbl(int tt);  return ((tt / CPP) % HT) >= HV; endfunction
  function automatic bit e_vbl(int tt);  return e_line(tt) >= VV; endfunction
  function automatic bit e_hrise(int tt); return (tt % LINE) == HV * CPP; endfunction
  function automatic bit e_vrise(int tt); return (tt % FRAME) == VV * LINE; endfunction
  function automatic bit e_lstart(int tt); return (tt % LINE) == 0; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] v);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic to_frame_start();
    @(negedge clk);
    while ((t % FRAME) != 0) @(negedge clk);
  endtask

  // R8: reset state
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(cfg_rdata == 16'h0004, "R8 rdata", cfg_rdata, 16'h0004);
    check(line_num == 8'd0 && !hblank && !vblank, "R8 raster", {line_num, hblank, vblank}, 0);
    check(!irq_vblank && !irq_hblank && !irq_match, "R8 irqs",
          {irq_vblank, irq_hblank, irq_match}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(t == 1 && line_num == 8'd0 && !hblank, "R8 leaves reset", t, 1);
  endtask

  // R1 R2 R3: raster over two frames
  task automatic t_scan();
    int bad_h = 0, bad_v = 0, bad_l = 0, bad_s = 0;
    for (int i = 0; i < 2 * FRAME; i++) begin
      if (hblank !== e_hbl(t)) bad_h++;
      if (vblank !== e_vbl(t)) bad_v++;
      if (line_num !== 8'(e_line(t))) bad_l++;
      if (cfg_rdata[1:0] !== {e_hbl(t), e_vbl(t)}) bad_s++;
      @(negedge clk);
    end
    check(bad_h == 0, "R1 hblank timing", bad_h, 0);
    check(bad_l == 0, "R2 line count", bad_l, 0);
    check(bad_v == 0, "R2 vblank", bad_v, 0);
    check(bad_s == 0, "R3 status bits 1:0", bad_s, 0);
  endtask

  // R4 R5: all interrupts on, trigger line 3
  task automatic t_irq_all();
    int bad_i = 0, bad_m = 0, nh = 0, nv = 0, nm = 0;
    cfg_write(16'h0338);
    check(cfg_rdata[15:3] == 13'h0067, "R3 cfg readback", cfg_rdata[15:3], 13'h0067);
    to_frame_start();
    for (int i = 0; i < 2 * FRAME; i++) begin
      if (irq_hblank !== e_hrise(t)) bad_i++;
      if (irq_vblank !== e_vrise(t)) bad_i++;
      if (irq_match !== (e_lstart(t) && e_line(t) == 3)) bad_i++;
      if (cfg_rdata[2] !== (e_line(t) == 3)) bad_m++;
      nh += int'(irq_hblank); nv += int'(irq_vblank); nm += int'(irq_match);
      @(negedge clk);
    end
    check(bad_i == 0, "R5 pulse timing", bad_i, 0);
    check(nh == 2 * VT, "R5 hblank pulse count", nh, 2 * VT);
    check(nv == 2 && nm == 2, "R5 vblank/match pulse count", nv * 100 + nm, 202);
    check(bad_m == 0, "R4 match flag", bad_m, 0);
  endtask

  // R6: enables off, flags still move
  task automatic t_gate();
    int np = 0, nhb = 0;
    cfg_write(16'h0300);
    to_frame_start();
    for (int i = 0; i < FRAME; i++) begin
      np += int'(irq_hblank) + int'(irq_vblank) + int'(irq_match);
      nhb += int'(hblank);
      @(negedge clk);
    end
    check(np == 0, "R6 no pulses when disabled", np, 0);
    check(nhb == VT * HB * CPP, "R6 flags keep running", nhb, VT * HB * CPP);
  endtask

  // R4: trigger on last line and on line 0 (frame wrap)
  task automatic t_trig_edge();
    int bad = 0;
    cfg_write(16'h0720);
    to_frame_start();
    for (int i = 0; i < FRAME; i++) begin
      if (irq_match !== (e_lstart(t) && e_line(t) == VT - 1)) bad++;
      if (cfg_rdata[2] !== (e_line(t) == VT - 1)) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R4 trigger on last blank line", bad, 0);
    bad = 0;
    cfg_write(16'h0020);
    to_frame_start();
    for (int i = 0; i < FRAME; i++) begin
      if (irq_match !== (e_lstart(t) && e_line(t) == 0)) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R4 trigger on line 0 across wrap", bad, 0);
  endtask

  // R7: read-only and spare bits ignore writes
  task automatic t_ro();
    int nm = 0;
    cfg_write(16'hA5FF);
    check(cfg_rdata[15:3] == {8'hA5, 2'b00, 3'b111}, "R7 writable fields",
          cfg_rdata[15:3], {8'hA5, 2'b00, 3'b111});
    check(cfg_rdata[2:0] == {1'b0, e_hbl(t), e_vbl(t)}, "R7 flags ignore write",
          cfg_rdata[2:0], {1'b0, e_hbl(t), e_vbl(t)});
    for (int i = 0; i < FRAME; i++) begin
      nm += int'(irq_match);
      @(negedge clk);
    end
    check(nm == 0, "R7 trigger beyond frame never matches", nm, 0);
  endtask

  // R9: trigger moved onto the current line mid-line
  task automatic t_midline();
    int ln;
    @(negedge clk);
    while ((t % LINE) != 5) @(negedge clk);
    ln = e_line(t);
    check(irq_match == 1'b0, "R9 quiet before write", irq_match, 0);
    cfg_write({8'(ln), 8'h20});
    check(irq_match == 1'b1, "R9 pulse after write", irq_match, 1);
    @(negedge clk);
    check(irq_match == 1'b0, "R9 single pulse", irq_match, 0);
  endtask

  initial begin
    t_reset();
    t_scan();
    t_irq_all();
    t_gate();
    t_trig_edge();
    t_ro();
    t_midline();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule